// File: doc/BRIEF.md
# Ignition Coil Compare Scheduler

This block drives the transistors of two ignition coils. Each coil serves a pair of cylinders that fire 360 degrees apart. A free-running timebase advances at one quarter-megahertz rate. Its tick is made by dividing a system clock-enable. Software chooses the next level of each coil on a level-select input. It then sends a match time into a small compare queue. When the timebase reaches the time at the head of the queue, the entry retires. If that entry holds the output role, both coil outputs load their level-select bits. A 0 energizes the coil (dwell start) and a 1 releases it (spark). The level-select bits must stay unchanged from the write until that match.

The role of each entry is fixed when the entry is accepted. An entry accepted into an empty queue takes the output role. An entry accepted while another is pending takes the interrupt role. At its match, an interrupt-role entry only raises a one-cycle interrupt pulse and leaves the coils alone. Software that wants a callback at the dwell or spark instant therefore writes the same time twice. Software that wants no callback writes it once. Each role has a capture register that holds the timebase value at its most recent match.

Match times enter on a valid/ready stream. A time is accepted on a clock where `cmp_valid` and `cmp_ready` are both high. `cmp_ready` depends only on how many entries are pending, and it drops while two are pending. A sender that sees `cmp_ready` low must hold its time and `cmp_valid` until `cmp_ready` returns. A time offered while `cmp_ready` is low is not stored.

Top module: `coil_cmp_sched`

## Requirements
- R1: The timebase resets to 0. It advances by exactly one on every SYS_DIV-th clock on which `sys_ce` is high, and on no other clock.
- R2: The queue holds at most two entries, and `cmp_ready` is high exactly when fewer than two are pending. A time offered while `cmp_ready` is low is not stored: the queue, the outputs and the later matches are as if it had never been offered.
- R3: An entry accepted while the queue is empty takes the output role. At its match, `coil_q` loads `lvl_sel` and no interrupt pulse occurs.
- R4: An entry accepted while one entry is pending takes the interrupt role. At its match, `irq` is high for exactly one clock and `coil_q` does not change.
- R5: An entry matches when the timebase equals its time. The output reacts on the clock edge after the first clock on which the timebase equals the time of the head entry. Entries retire in the order they were accepted, and at most one retires per clock. A second entry with the same time therefore retires on the next clock.
- R6: Bit 0 of `lvl_sel` and `coil_q` belongs to the cylinder 1/4 coil, and bit 1 belongs to the cylinder 2/3 coil. A value of 0 energizes the coil and 1 releases it.
- R7: `cap_out` holds the timebase value at the most recent output-role match, and `cap_irq` holds the value at the most recent interrupt-role match. Both reset to 0.
- R8: The timebase wraps modulo 2^TW. An entry whose time has already passed waits for the wrap and then matches.
- R9: During and right after reset, `cmp_ready` is 1, `coil_q` is all ones (released) and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_ce | input | 1 | System clock-enable feeding the timebase divider |
| cmp_valid | input | 1 | Match time offered |
| cmp_ready | output | 1 | Queue can accept a match time |
| cmp_time | input | TW | Match time in timebase ticks |
| lvl_sel | input | NCOIL | Level each coil takes at the next output-role match |
| coil_q | output | NCOIL | Coil driver levels, 0 = energized |
| irq | output | 1 | One-cycle coil interrupt pulse |
| cap_out | output | TW | Timebase at the last output-role match |
| cap_irq | output | TW | Timebase at the last interrupt-role match |

## Verification
The bench builds the block with SYS_DIV=2 and TW=8. With these values the timebase wraps every 512 clocks, which makes the wrap-around wait for an already-passed time short enough to test directly. Directed phases cover:
- single and paired writes;
- a write offered into a full queue;
- a wrap-around match.

A long phase follows that thins out `sys_ce` and offers times at random, so the divider count, back-to-back matches and simultaneous accept-and-retire are all reached.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic {ROLE_OUT = 1'b0, ROLE_IRQ = 1'b1} role_e;
endpackage

// File: rtl/ccs_timebase.sv
module ccs_timebase #(
  parameter int SYS_DIV = 8,
  parameter int TW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_ce,
  output logic          tick,
  output logic [TW-1:0] now
);
  localparam int DIV_W = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = sys_ce && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      now   <= '0;
    end else begin
      if (sys_ce) div_q <= tick ? '0 : div_q + 1'b1;
      if (tick)   now   <= now + 1'b1;
    end
  end
endmodule

// File: rtl/ccs_cmp_queue.sv
module ccs_cmp_queue
  import ccs_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [TW-1:0] push_time,
  input  logic [TW-1:0] now,
  output logic          fire,
  output role_e         fire_role,
  output logic [1:0]    count
);
  localparam int DEPTH = 2;

  logic [TW-1:0] slot_t [DEPTH];
  role_e         slot_r [DEPTH];
  logic          push_ok;
  logic          wr_idx;
  role_e         new_role;

  assign push_ready = (count < 2'(DEPTH));
  assign push_ok    = push_valid && push_ready;
  assign fire       = (count != 2'd0) && (slot_t[0] == now);
  assign fire_role  = slot_r[0];
  assign new_role   = (count == 2'd0) ? ROLE_OUT : ROLE_IRQ;
  assign wr_idx     = 1'(count - {1'b0, fire});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_t[i] <= '0;
        slot_r[i] <= ROLE_OUT;
      end
    end else begin
      if (fire) begin
        slot_t[0] <= slot_t[1];
        slot_r[0] <= slot_r[1];
      end
      if (push_ok) begin
        slot_t[wr_idx] <= push_time;
        slot_r[wr_idx] <= new_role;
      end
      count <= count + {1'b0, push_ok} - {1'b0, fire};
    end
  end
endmodule

// File: rtl/ccs_out_latch.sv
module ccs_out_latch
  import ccs_pkg::*;
#(
  parameter int NCOIL = 2,
  parameter int TW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  role_e            fire_role,
  input  logic [TW-1:0]    now,
  input  logic [NCOIL-1:0] lvl_sel,
  output logic [NCOIL-1:0] coil_q,
  output logic             irq,
  output logic [TW-1:0]    cap_out,
  output logic [TW-1:0]    cap_irq
);
  logic hit_out;
  logic hit_irq;

  assign hit_out = fire && (fire_role == ROLE_OUT);
  assign hit_irq = fire && (fire_role == ROLE_IRQ);

  for (genvar g = 0; g < NCOIL; g++) begin : g_coil
    always_ff @(posedge clk) begin
      if (!rst_n)       coil_q[g] <= 1'b1;
      else if (hit_out) coil_q[g] <= lvl_sel[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      cap_out <= '0;
      cap_irq <= '0;
    end else begin
      irq <= hit_irq;
      if (hit_out) cap_out <= now;
      if (hit_irq) cap_irq <= now;
    end
  end
endmodule

// File: rtl/coil_cmp_sched.sv
module coil_cmp_sched
  import ccs_pkg::*;
#(
  parameter int SYS_DIV = 8,
  parameter int TW      = 16,
  parameter int NCOIL   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_ce,
  input  logic             cmp_valid,
  output logic             cmp_ready,
  input  logic [TW-1:0]    cmp_time,
  input  logic [NCOIL-1:0] lvl_sel,
  output logic [NCOIL-1:0] coil_q,
  output logic             irq,
  output logic [TW-1:0]    cap_out,
  output logic [TW-1:0]    cap_irq
);
  logic          tick;
  logic [TW-1:0] tb_now;
  logic          fire;
  role_e         fire_role;
  logic [1:0]    q_cnt;

  ccs_timebase #(.SYS_DIV(SYS_DIV), .TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .tick(tick), .now(tb_now)
  );

  ccs_cmp_queue #(.TW(TW)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push_valid(cmp_valid), .push_ready(cmp_ready), .push_time(cmp_time),
    .now(tb_now), .fire(fire), .fire_role(fire_role), .count(q_cnt)
  );

  ccs_out_latch #(.NCOIL(NCOIL), .TW(TW)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_role(fire_role),
    .now(tb_now), .lvl_sel(lvl_sel), .coil_q(coil_q), .irq(irq),
    .cap_out(cap_out), .cap_irq(cap_irq)
  );
endmodule

// File: rtl/ccs_sva.sv
module ccs_sva
  import ccs_pkg::*;
#(
  parameter int TW    = 16,
  parameter int NCOIL = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [TW-1:0]    tb_now,
  input logic             fire,
  input role_e            fire_role,
  input logic [1:0]       q_cnt,
  input logic             cmp_valid,
  input logic             cmp_ready,
  input logic [NCOIL-1:0] coil_q,
  input logic             irq,
  input logic [TW-1:0]    cap_out
);
  p_tick_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tb_now == TW'($past(tb_now) + 1'b1));

  p_no_tick_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tb_now));

  p_accept_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && !fire) |=> q_cnt == $past(q_cnt) + 2'd1);

  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == 2'd2 && !fire) |=> q_cnt == 2'd2);

  p_coil_only_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && fire_role == ROLE_OUT) |=> $stable(coil_q));

  p_irq_keeps_coil_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $stable(coil_q));

  p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && fire_role == ROLE_OUT) |=> $stable(cap_out));
endmodule

bind coil_cmp_sched ccs_sva #(.TW(TW), .NCOIL(NCOIL)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tb_now(tb_now), .fire(fire),
  .fire_role(fire_role), .q_cnt(q_cnt), .cmp_valid(cmp_valid),
  .cmp_ready(cmp_ready), .coil_q(coil_q), .irq(irq), .cap_out(cap_out)
);

// File: tb/coil_cmp_sched_tb_top.sv
module coil_cmp_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_DIV = 2;
  localparam int TW = 8;
  localparam int NCOIL = 2;
  localparam int WRAP = 1 << TW;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_ce = 1'b1;
  logic cmp_valid = 1'b0;
  logic [TW-1:0] cmp_time = '0;
  logic [NCOIL-1:0] lvl_sel = '1;
  logic cmp_ready, irq;
  logic [NCOIL-1:0] coil_q;
  logic [TW-1:0] cap_out, cap_irq;

  int n_cmp = 0, n_bad = 0, cyc = 0, irq_seen = 0;
  int t_coil = -1, t_irq = -1;
  bit finished = 0;

  // reference model state
  int m_now = 0, m_div = 0, m_cap_o = 0, m_cap_i = 0;
  int m_coil = (1 << NCOIL) - 1;
  bit m_irq = 0;
  int q_t[$];
  bit q_o[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  coil_cmp_sched #(.SYS_DIV(SYS_DIV), .TW(TW), .NCOIL(NCOIL)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .cmp_valid(cmp_valid),
    .cmp_ready(cmp_ready), .cmp_time(cmp_time), .lvl_sel(lvl_sel),
    .coil_q(coil_q), .irq(irq), .cap_out(cap_out), .cap_irq(cap_irq)
  );

  always @(posedge clk) begin
    int sz;
    cyc++;
    if (!rst_n) begin
      m_now = 0; m_div = 0; m_cap_o = 0; m_cap_i = 0;
      m_coil = (1 << NCOIL) - 1; m_irq = 0;
      q_t.delete(); q_o.delete();
    end else begin
      sz = q_t.size();
      m_irq = 0;
      if (sz > 0 && q_t[0] == m_now) begin
        if (q_o[0]) begin m_coil = int'(lvl_sel); m_cap_o = m_now; end
        else begin m_irq = 1; m_cap_i = m_now; end
        void'(q_t.pop_front()); void'(q_o.pop_front());
      end
      if (cmp_valid && sz < 2) begin
        q_t.push_back(int'(cmp_time));
        q_o.push_back(sz == 0);
      end
      if (sys_ce) begin
        if (m_div == SYS_DIV - 1) begin m_div = 0; m_now = (m_now + 1) % WRAP; end
        else m_div++;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk("R9 ready", int'(cmp_ready), 1);
        chk("R9 coil", int'(coil_q), (1 << NCOIL) - 1);
        chk("R9 irq", int'(irq), 0);
      end else begin
        chk("R2 ready", int'(cmp_ready), int'(q_t.size() < 2));
        chk("R3 R6 coil", int'(coil_q), m_coil);
        chk("R4 irq", int'(irq), int'(m_irq));
        chk("R1 R7 cap_out", int'(cap_out), m_cap_o);
        chk("R1 R7 cap_irq", int'(cap_irq), m_cap_i);
      end
      if (irq) begin irq_seen++; t_irq = cyc; end
    end
  end

  logic [NCOIL-1:0] coil_d = '1;
  always @(negedge clk) begin
    if (coil_q != coil_d) t_coil = cyc;
    coil_d = coil_q;
  end

  task automatic wr(int t);
    bit acc;
    cmp_valid = 1'b1; cmp_time = TW'(t);
    do begin acc = cmp_ready; @(negedge clk); end while (!acc);
    cmp_valid = 1'b0;
  endtask

  task automatic poke(int t);
    cmp_valid = 1'b1; cmp_time = TW'(t);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    summary();
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R3 R6: single write, coil 1/4 energized (bit0=0), 2/3 released
    lvl_sel = 2'b10;
    irq_seen = 0;
    wr((m_now + 5) % WRAP);
    idle(20);
    chk("R6 coil map", int'(coil_q), 2);
    chk("R3 no irq on single", irq_seen, 0);

    // R4 R5: paired write with same time
    lvl_sel = 2'b01;
    irq_seen = 0;
    base = (m_now + 6) % WRAP;
    wr(base); wr(base);
    chk("R2 full not ready", int'(cmp_ready), 0);
    poke((base + 2) % WRAP);  // R2: offered while full, must be dropped
    idle(30);
    chk("R4 one irq on pair", irq_seen, 1);
    chk("R5 irq one clock after coil", t_irq - t_coil, 1);
    chk("R6 coil after pair", int'(coil_q), 1);
    chk("R7 caps equal", int'(cap_out), int'(cap_irq));

    // R5: distinct times in order
    lvl_sel = 2'b00;
    wr((m_now + 4) % WRAP); wr((m_now + 8) % WRAP);
    idle(30);
    chk("R5 coil energized both", int'(coil_q), 0);

    // R8: time already passed waits for wrap
    lvl_sel = 2'b11;
    wr((m_now + WRAP - 2) % WRAP);
    idle(SYS_DIV * (WRAP - 6));
    chk("R8 not yet matched", int'(coil_q), 0);
    idle(SYS_DIV * 10);
    chk("R8 matched after wrap", int'(coil_q), 3);

    // R1 R2 R5: random sys_ce, level and offers
    for (int i = 0; i < 3000; i++) begin
      sys_ce = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) lvl_sel = NCOIL'($urandom);
      if (($urandom % 5) == 0) begin
        cmp_valid = 1'b1;
        cmp_time = TW'(m_now + ($urandom % 6));
      end else cmp_valid = 1'b0;
      @(negedge clk);
    end
    cmp_valid = 1'b0; sys_ce = 1'b1;
    idle(SYS_DIV * WRAP + 8);
    summary();
  end
endmodule